// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Target

This block sits on a two-wire serial bus as a target device and gives an external bus controller access to an on-chip register file. A strap input picks which of two fixed 7-bit bus addresses the block answers to. Every access starts by writing a one-byte register pointer. Data bytes that follow in the same write phase are stored at the pointer. To read, the controller opens a new read-direction phase, and the block returns bytes starting at the pointer. The pointer advances by one after every byte moved in either direction.

SCL and SDA arrive as raw samples and pass through a synchroniser first. The block pulls SDA low through an open-drain enable, and it changes that enable only while the synchronised SCL is low. Towards the register file it offers a pointer output, a write strobe with data, and a read strobe. The read data must be valid in the same clock as the read strobe. The pointer holds its value across a STOP, so a read can follow either a repeated START or a STOP and then a new START.

Top module: `i2cRegTarget`

## Requirements
- R1: With `addrSel` high the block answers to 7-bit address 0x1D, which is address byte 0x3A to write and 0x3B to read. It pulls SDA low in the acknowledge bit.
- R2: With `addrSel` low the block answers to 7-bit address 0x53, which is address byte 0xA6 to write and 0xA7 to read.
- R3: If the address byte does not match the selected address, the block leaves SDA released in the acknowledge bit and in every later bit. It issues no register strobes until the next START.
- R4: In a write phase, the first byte after the address loads the pointer. Each later byte is acknowledged and written at the pointer, and the pointer then advances by one. The 8-bit pointer wraps from 0xFF to 0x00.
- R5: After a read-direction address that follows a repeated START, the block sends the register at the pointer, most significant bit first. The pointer advances by one after each byte. The block keeps sending while the controller acknowledges.
- R6: The pointer is kept across a STOP. A read phase that opens with STOP and then START returns data from the pointer that was written before the STOP.
- R7: When the controller does not acknowledge a read byte, the block releases SDA and fetches no more bytes. The number of read strobes equals the number of bytes transferred.
- R8: START is a falling SDA and STOP a rising SDA, each while SCL is high, and a STOP returns the block to idle. The SDA enable changes only while SCL is low.
- R9: The block works with SCL at 100 kHz and at 400 kHz from a 50 MHz system clock.
- R10: After reset, SDA is released and neither register strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw SCL level from the pad |
| sdaIn | input | 1 | Raw SDA level from the pad |
| addrSel | input | 1 | Address strap: 1 selects 0x1D, 0 selects 0x53 |
| sdaDriveLow | output | 1 | 1 pulls SDA low (open-drain enable) |
| regAddr | output | PTR_W | Register pointer presented to the register file |
| regWrData | output | 8 | Byte to store at regAddr |
| regWrEn | output | 1 | One-cycle write strobe |
| regRdEn | output | 1 | One-cycle read strobe |
| regRdData | input | 8 | Register contents at regAddr, valid while regRdEn is high |

## Verification
Two events land in the same clock in this block. In a write, storing a byte and advancing the pointer happen together, and the stored byte must use the pointer value from before the increment. In a read, fetching the next byte happens as the controller's acknowledge is sampled, just before the first bit of that byte is driven. Multi-byte bursts provoke both, including a burst that crosses 0xFF to 0x00. A scoreboard judges them by comparing every write strobe's address and data, in order, against the queue the driver filled, and by comparing every byte read back, bit by bit, against the bench's own shadow of the register contents.

// File: rtl/i2cTgtPkg.sv
package i2cTgtPkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK_W, S_ADDR_ACK_R, S_PTR, S_PTR_ACK,
    S_WDATA, S_WDATA_ACK, S_RDATA, S_RDATA_ACK
  } tgtStateT;

  typedef struct packed {
    logic shiftRx;
    logic loadPtr;
    logic incPtr;
    logic loadTx;
    logic driveAck;
    logic driveBit;
    logic relSda;
    logic wrEn;
    logic rdEn;
  } tgtStrobeT;
endpackage

// File: rtl/i2cTgtDatapath.sv
module i2cTgtDatapath
  import i2cTgtPkg::*;
#(
  parameter int PTR_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_HI = 7'h1D,
  parameter logic [6:0] ADDR_LO = 7'h53
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrSel,
  input  tgtStrobeT         stb,
  input  logic [BYTE_W-1:0] regRdData,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              sdaBit,
  output logic [BYTE_W-1:0] rxByte,
  output logic              addrHit,
  output logic [PTR_W-1:0]  ptr,
  output logic              sdaOe
);
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev, sclS;
  logic [BYTE_W-1:0] txByte;
  logic [6:0] ownAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclSync[SYNC_STAGES-1];
      sdaPrev <= sdaSync[SYNC_STAGES-1];
    end
  end

  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaBit   = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaBit;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaBit;

  assign ownAddr = addrSel ? ADDR_HI : ADDR_LO;
  assign addrHit = (rxByte[7:1] == ownAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      txByte <= '0;
      ptr    <= '0;
      sdaOe  <= 1'b0;
    end else begin
      if (stb.shiftRx) rxByte <= {rxByte[BYTE_W-2:0], sdaBit};
      if (stb.loadPtr) ptr <= PTR_W'(rxByte);
      else if (stb.incPtr) ptr <= ptr + 1'b1;
      if (stb.loadTx) txByte <= regRdData;
      else if (stb.driveBit) txByte <= {txByte[BYTE_W-2:0], 1'b0};
      if (stb.relSda) sdaOe <= 1'b0;
      else if (stb.driveAck) sdaOe <= 1'b1;
      else if (stb.driveBit) sdaOe <= ~txByte[BYTE_W-1];
    end
  end

  // R8: the open-drain enable moves only while the synchronised SCL is low
  a_r8_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !$past(sclS));
endmodule

// File: rtl/i2cTgtControl.sv
module i2cTgtControl
  import i2cTgtPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic      sdaBit,
  input  logic      rxRw,
  input  logic      addrHit,
  output tgtStrobeT stb
);
  tgtStateT state, stateN;
  logic [3:0] bitCnt, bitCntN;
  logic ackSeen, ackSeenN;
  logic byteDone;

  assign byteDone = sclFall && (bitCnt == 4'd8);

  always_comb begin
    stb      = '0;
    stateN   = state;
    bitCntN  = bitCnt;
    ackSeenN = ackSeen;
    if (startDet) begin
      stateN     = S_ADDR;
      bitCntN    = '0;
      stb.relSda = 1'b1;
    end else if (stopDet) begin
      stateN     = S_IDLE;
      stb.relSda = 1'b1;
    end else begin
      unique case (state)
        S_ADDR, S_PTR, S_WDATA: begin
          if (sclRise) begin
            stb.shiftRx = 1'b1;
            bitCntN     = bitCnt + 1'b1;
          end else if (byteDone) begin
            bitCntN = '0;
            if (state == S_ADDR) begin
              if (!addrHit) begin
                stateN     = S_IDLE;
                stb.relSda = 1'b1;
              end else if (rxRw) begin
                stb.driveAck = 1'b1;
                stb.rdEn     = 1'b1;
                stb.loadTx   = 1'b1;
                stateN       = S_ADDR_ACK_R;
              end else begin
                stb.driveAck = 1'b1;
                stateN       = S_ADDR_ACK_W;
              end
            end else if (state == S_PTR) begin
              stb.loadPtr  = 1'b1;
              stb.driveAck = 1'b1;
              stateN       = S_PTR_ACK;
            end else begin
              stb.wrEn     = 1'b1;
              stb.incPtr   = 1'b1;
              stb.driveAck = 1'b1;
              stateN       = S_WDATA_ACK;
            end
          end
        end
        S_ADDR_ACK_W, S_PTR_ACK, S_WDATA_ACK: begin
          if (sclFall) begin
            stb.relSda = 1'b1;
            bitCntN    = '0;
            stateN     = (state == S_ADDR_ACK_W) ? S_PTR : S_WDATA;
          end
        end
        S_ADDR_ACK_R: begin
          if (sclFall) begin
            stb.driveBit = 1'b1;
            bitCntN      = '0;
            stateN       = S_RDATA;
          end
        end
        S_RDATA: begin
          if (sclRise) bitCntN = bitCnt + 1'b1;
          else if (byteDone) begin
            stb.relSda = 1'b1;
            stb.incPtr = 1'b1;
            ackSeenN   = 1'b0;
            stateN     = S_RDATA_ACK;
          end else if (sclFall) stb.driveBit = 1'b1;
        end
        S_RDATA_ACK: begin
          if (sclRise && !sdaBit) begin
            ackSeenN   = 1'b1;
            stb.rdEn   = 1'b1;
            stb.loadTx = 1'b1;
          end else if (sclFall) begin
            bitCntN = '0;
            if (ackSeen) begin
              stb.driveBit = 1'b1;
              stateN       = S_RDATA;
            end else begin
              stb.relSda = 1'b1;
              stateN     = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      bitCnt  <= '0;
      ackSeen <= 1'b0;
    end else begin
      state   <= stateN;
      bitCnt  <= bitCntN;
      ackSeen <= ackSeenN;
    end
  end

  // R4 / R5: a register access is either a store or a fetch, never both
  a_r4_one_access: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrEn, stb.rdEn}));
  // R8: a STOP always lands the sequencer in idle
  a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == S_IDLE));
  // R3: a foreign address ends the transfer at the acknowledge slot
  a_r3_miss_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ADDR && byteDone && !addrHit && !startDet && !stopDet)
      |=> (state == S_IDLE));
endmodule

// File: rtl/i2cRegTarget.sv
module i2cRegTarget
  import i2cTgtPkg::*;
#(
  parameter int PTR_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_HI = 7'h1D,
  parameter logic [6:0] ADDR_LO = 7'h53
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             addrSel,
  output logic             sdaDriveLow,
  output logic [PTR_W-1:0] regAddr,
  output logic [7:0]       regWrData,
  output logic             regWrEn,
  output logic             regRdEn,
  input  logic [7:0]       regRdData
);
  tgtStrobeT stb;
  logic sclRise, sclFall, startDet, stopDet, sdaBit, addrHit;
  logic [BYTE_W-1:0] rxByte;

  i2cTgtDatapath #(
    .PTR_W(PTR_W), .SYNC_STAGES(SYNC_STAGES), .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrSel(addrSel),
    .stb(stb), .regRdData(regRdData), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit), .rxByte(rxByte),
    .addrHit(addrHit), .ptr(regAddr), .sdaOe(sdaDriveLow)
  );

  i2cTgtControl ctrl_i (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit), .rxRw(rxByte[0]),
    .addrHit(addrHit), .stb(stb)
  );

  assign regWrData = rxByte;
  assign regWrEn   = stb.wrEn;
  assign regRdEn   = stb.rdEn;

  // R4: every stored byte is acknowledged in the following clock
  a_r4_store_acked: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> sdaDriveLow);
endmodule

// File: tb/i2cRegTarget_tb_top.sv
module i2cRegTarget_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic addrSel = 1'b1;
  logic sdaDriveLow, regWrEn, regRdEn;
  logic [7:0] regAddr, regWrData, regRdData;
  logic sdaLine;
  logic [7:0] regFile [256];
  logic [7:0] shadow [256];
  int hp = 62;
  int nChecks = 0;
  int nErr = 0;
  int rdCount = 0;
  int oeViol = 0;
  logic prevOe = 1'b0;

  typedef struct { logic [7:0] a; logic [7:0] d; } wrItemT;
  wrItemT expQ[$];

  always #10 clk = ~clk;

  assign sdaLine = mSda & ~sdaDriveLow;
  assign regRdData = regFile[regAddr];

  i2cRegTarget dut_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .addrSel(addrSel),
    .sdaDriveLow(sdaDriveLow), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regRdData(regRdData)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (regWrEn) regFile[regAddr] <= regWrData;

  // scoreboard monitor: pops one expected store per write strobe
  always @(negedge clk) begin
    if (regWrEn) begin
      if (expQ.size() == 0) chk(1'b0, "R3 unexpected store", {regAddr, regWrData}, 0);
      else begin
        wrItemT it;
        it = expQ.pop_front();
        chk({regAddr, regWrData} == {it.a, it.d}, "R4 store addr/data",
            {regAddr, regWrData}, {it.a, it.d});
      end
    end
    if (regRdEn) rdCount++;
    if (rstN && sdaDriveLow != prevOe && mScl) oeViol++;
    prevOe <= sdaDriveLow;
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    mSda = 1'b1; waitClk(hp);
    mScl = 1'b1; waitClk(hp);
    mSda = 1'b0; waitClk(hp);
    mScl = 1'b0; waitClk(hp);
  endtask

  task automatic stopCond();
    mSda = 1'b0; waitClk(hp);
    mScl = 1'b1; waitClk(hp);
    mSda = 1'b1; waitClk(hp);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitClk(hp);
      mScl = 1'b1; waitClk(hp);
      mScl = 1'b0;
    end
    mSda = 1'b1; waitClk(hp);
    mScl = 1'b1; waitClk(hp / 2);
    acked = (sdaLine == 1'b0);
    waitClk(hp - hp / 2);
    mScl = 1'b0;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitClk(hp);
      mScl = 1'b1; waitClk(hp / 2);
      b[i] = sdaLine;
      waitClk(hp - hp / 2);
      mScl = 1'b0;
    end
    mSda = giveAck ? 1'b0 : 1'b1; waitClk(hp);
    mScl = 1'b1; waitClk(hp);
    mScl = 1'b0;
  endtask

  task automatic doWrite(input logic [6:0] a, input logic [7:0] p, input int n,
                         input logic [7:0] seed, input string req);
    bit ack;
    startCond();
    sendByte({a, 1'b0}, ack); chk(ack, {req, " address ack"}, ack, 1);
    sendByte(p, ack);         chk(ack, {req, " pointer ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      wrItemT it;
      it.a = p + 8'(i);
      it.d = seed + 8'(i * 37);
      expQ.push_back(it);
      shadow[it.a] = it.d;
      sendByte(it.d, ack); chk(ack, {req, " data ack"}, ack, 1);
    end
    stopCond();
    chk(expQ.size() == 0, {req, " all stores seen"}, expQ.size(), 0);
  endtask

  task automatic doRead(input logic [6:0] a, input logic [7:0] p, input int n,
                        input bit restart, input string req);
    bit ack;
    int rdBefore;
    logic [7:0] b;
    startCond();
    sendByte({a, 1'b0}, ack); chk(ack, {req, " address ack"}, ack, 1);
    sendByte(p, ack);         chk(ack, {req, " pointer ack"}, ack, 1);
    if (!restart) begin
      stopCond(); waitClk(hp);
    end
    rdBefore = rdCount;
    startCond();
    sendByte({a, 1'b1}, ack); chk(ack, {req, " read address ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i < n - 1, b);
      chk(b == shadow[p + 8'(i)], {req, " read data"}, b, shadow[p + 8'(i)]);
    end
    waitClk(4);
    chk(sdaDriveLow == 1'b0, "R7 SDA released after NACK", sdaDriveLow, 0);
    stopCond();
    chk(rdCount - rdBefore == n, "R7 fetch count", rdCount - rdBefore, n);
  endtask

  task automatic doMiss(input logic [6:0] a, input string req);
    bit ack;
    int rdBefore;
    rdBefore = rdCount;
    startCond();
    sendByte({a, 1'b0}, ack); chk(!ack, {req, " foreign address NACK"}, ack, 0);
    sendByte(8'h10, ack);     chk(!ack, "R3 later byte NACK", ack, 0);
    sendByte(8'hC3, ack);     chk(!ack, "R3 later byte NACK", ack, 0);
    stopCond();
    chk(rdCount == rdBefore, "R3 no fetch", rdCount - rdBefore, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      regFile[i] = 8'(i) ^ 8'h5A;
      shadow[i]  = 8'(i) ^ 8'h5A;
    end
    waitClk(5);
    rstN = 1'b1;
    waitClk(2);
    // R10: idle after reset
    chk(sdaDriveLow == 1'b0, "R10 SDA released", sdaDriveLow, 0);
    chk(regWrEn == 1'b0 && regRdEn == 1'b0, "R10 strobes idle", {regWrEn, regRdEn}, 0);
    waitClk(hp);

    // 400 kHz, strap high (R1, R9)
    addrSel = 1'b1;
    doWrite(7'h1D, 8'h20, 4, 8'h11, "R1 R4 burst write 0x3A");
    doRead(7'h1D, 8'h20, 4, 1'b1, "R1 R5 repeated-start read 0x3B");
    doRead(7'h1D, 8'h21, 2, 1'b0, "R6 stop-start read");
    doWrite(7'h1D, 8'hFE, 3, 8'h90, "R4 pointer wrap write");
    doRead(7'h1D, 8'hFE, 3, 1'b1, "R5 pointer wrap read");
    doWrite(7'h1D, 8'h40, 1, 8'hA5, "R4 single write");
    doRead(7'h1D, 8'h40, 1, 1'b0, "R6 single read");
    doMiss(7'h53, "R3 strap high");

    // strap low (R2)
    addrSel = 1'b0;
    waitClk(hp);
    doMiss(7'h1D, "R3 strap low");
    doWrite(7'h53, 8'h07, 2, 8'h3C, "R2 write 0xA6");
    doRead(7'h53, 8'h07, 2, 1'b1, "R2 read 0xA7");

    // 100 kHz (R9)
    hp = 250;
    doWrite(7'h53, 8'h80, 2, 8'h66, "R9 slow write");
    doRead(7'h53, 8'h80, 2, 1'b1, "R9 slow read");

    chk(oeViol == 0, "R8 SDA changed while SCL high", oeViol, 0);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule